// File: doc/BRIEF.md
# SPI banked register command interpreter

This block is an SPI slave (mode 0, framed by an active-low chip select). It takes a one-byte command, then carries it out against a banked file of 8-bit control registers and a byte-wide buffer RAM that sits inside the block. A command byte holds a 3-bit opcode in bits 7:5 and a 5-bit register address in bits 4:0. The supported commands are: register read, register write, bit-field set, bit-field clear, streamed buffer read, streamed buffer write, and a soft reset. The buffer is reached through two 13-bit pointers that live in the register file. When enabled, each pointer steps forward after every buffer byte that is transferred. The RAM depth is a parameter, and the pointer's low bits index it.

The SPI pins are sampled in the system clock domain, and the block finds the serial clock edges there. The controller runs as a state machine with these states:
- `S_IDLE`: chip select is high.
- `S_CMD`: the command byte is being shifted in.
- `S_RDREG`: the read value is being returned.
- `S_WRREG`, `S_SETB`, `S_CLRB`: waiting for the data or mask byte.
- `S_BUFRD`, `S_BUFWR`: streaming to or from the buffer.
- `S_DONE`: the rest of the frame is ignored.

The transitions are:
- Chip select going active takes `S_IDLE` to `S_CMD`.
- The end of the command byte leaves `S_CMD` for the state that the command selects. The reset command and undefined command bytes go to `S_DONE`.
- The end of the data byte takes `S_RDREG`, `S_WRREG`, `S_SETB` and `S_CLRB` to `S_DONE`.
- The two buffer states stay where they are for the rest of the frame.
- Chip select going high returns every state to `S_IDLE`.

Top module: `spi_bank_cmd`

## Requirements
- R1: Opcode 000 returns the addressed register on the byte after the command, MSB first. Every later byte in that frame reads 0x00.
- R2: Opcode 010 writes the following data byte into the addressed register.
- R3: Opcode 100 ORs the following mask byte into the addressed register. Opcode 101 clears the bits that are set in the mask.
- R4: Bits 1:0 of the register at 0x1F select one of four banks. Addresses 0x00 to 0x19 hold separate storage in each bank.
- R5: Addresses 0x1B to 0x1F reach the same five registers whichever bank is selected.
- R6: Address 0x1A is reserved in every bank: it reads 0x00 and ignores writes. The pointer high bytes at bank 0 addresses 0x01 and 0x03 keep only bits 4:0, and their bits 7:5 read zero.
- R7: Command 0x3A streams bytes out of the buffer, starting at the read pointer {bank0 0x01[4:0], bank0 0x00}. Command 0x7A streams the following bytes into the buffer, starting at the write pointer {bank0 0x03[4:0], bank0 0x02}.
- R8: While bit 7 of register 0x1E is set, the pointer in use steps by one after each buffer byte and wraps from 0x1FFF to 0x0000. While that bit is clear, the pointer does not move and the stream keeps using one location.
- R9: Command 0xFF takes no data byte. It clears every register to zero, so bank 0 is selected, both pointers are 0x0000 and auto-increment is off.
- R10: Raising chip select ends the current command, and a partly shifted data byte has no effect. The first byte after chip select falls again is decoded as a command. Undefined command bytes change nothing.
- R11: MOSI is sampled on rising serial clock edges and MISO changes on falling edges. MISO stays low while the command byte is being shifted in.
- R12: Output `bank_o` always shows the bank currently selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the SPI pins are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select that frames each command |
| spi_mosi | input | 1 | Serial data in, MSB first |
| spi_miso | output | 1 | Serial data out, MSB first |
| bank_o | output | 2 | Currently selected register bank |

## Verification
A mirror of the registers and the buffer is kept in the bench, and it is driven with a seeded random mix of writes, sets, clears, reads, bank changes and buffer bursts. This mix separates the bank-relative addresses from the common ones, and bursts with auto-increment on from bursts with it off. Directed cases cover the points that random traffic would seldom reach:
- pointer wrap at 0x1FFF
- the reserved address and the masking of the pointer high bytes
- a read followed by extra bytes in the same frame
- a frame cut off in the middle of a data byte, and an undefined opcode
- the soft reset command

Each case shows whether the command ended at the correct byte boundary.

// File: rtl/spi_bank_cmd_pkg.sv
package spi_bank_cmd_pkg;
    localparam int ADDR_W    = 5;
    localparam int PTR_W     = 13;
    localparam int PTR_HI_W  = PTR_W - 8;
    localparam int NBANK     = 4;
    localparam int BANK_W    = $clog2(NBANK);
    localparam int COM_BASE  = 27;
    localparam int NCOM      = (1 << ADDR_W) - COM_BASE;
    localparam int CI_W      = $clog2(NCOM);
    localparam int RSV_ADDR  = 26;
    localparam int IDX_MODE  = 3;   // common slot for 0x1E
    localparam int IDX_SEL   = 4;   // common slot for 0x1F
    localparam int AUTOINC_BIT = 7;

    localparam logic [ADDR_W-1:0] A_RD_LO = 5'd0;
    localparam logic [ADDR_W-1:0] A_RD_HI = 5'd1;
    localparam logic [ADDR_W-1:0] A_WR_LO = 5'd2;
    localparam logic [ADDR_W-1:0] A_WR_HI = 5'd3;

    localparam logic [2:0] OPC_RDREG = 3'b000;
    localparam logic [2:0] OPC_WRREG = 3'b010;
    localparam logic [2:0] OPC_SETB  = 3'b100;
    localparam logic [2:0] OPC_CLRB  = 3'b101;
    localparam logic [7:0] CMD_BUFRD = 8'h3A;
    localparam logic [7:0] CMD_BUFWR = 8'h7A;
    localparam logic [7:0] CMD_RESET = 8'hFF;

    typedef enum logic [1:0] {OP_NONE, OP_WR, OP_SET, OP_CLR} reg_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_RDREG, S_WRREG, S_SETB, S_CLRB, S_BUFRD, S_BUFWR, S_DONE
    } fsm_e;
endpackage

// File: rtl/spi_bank_cmd_link.sv
module spi_bank_cmd_link (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       cs_act,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       miso
);
    localparam int CNT_W = 3;

    logic [1:0]       sclk_s, cs_s, mosi_s;
    logic             sclk_d;
    logic [CNT_W-1:0] bit_cnt;
    logic [6:0]       rx_sr;
    logic [7:0]       tx_sr;
    logic             rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_s <= '0;
            cs_s   <= '1;
            mosi_s <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_s <= {sclk_s[0], sclk};
            cs_s   <= {cs_s[0], cs_n};
            mosi_s <= {mosi_s[0], mosi};
            sclk_d <= sclk_s[1];
        end
    end

    assign cs_act = ~cs_s[1];
    assign rise   = cs_act & sclk_s[1] & ~sclk_d;
    assign fall   = cs_act & ~sclk_s[1] & sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
                rx_sr   <= '0;
                tx_sr   <= '0;
            end else begin
                if (rise) begin
                    rx_sr   <= {rx_sr[5:0], mosi_s[1]};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == '1) begin
                        byte_done <= 1'b1;
                        rx_byte   <= {rx_sr, mosi_s[1]};
                    end
                end
                if (fall)
                    tx_sr <= (bit_cnt == '0) ? tx_byte : {tx_sr[6:0], 1'b0};
            end
        end
    end

    assign miso = tx_sr[7];

    // MISO only moves on a detected falling edge (or when the frame closes)
    assert_miso_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && !fall) |=> (!cs_act || $stable(miso)));
endmodule

// File: rtl/spi_bank_cmd_regs.sv
module spi_bank_cmd_regs
    import spi_bank_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  reg_op_e           op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              rd_inc,
    input  logic              wr_inc,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [BANK_W-1:0] bank,
    output logic              autoinc
);
    logic [7:0] bnk_q [NBANK][COM_BASE];
    logic [7:0] com_q [NCOM];

    logic            is_com, is_rsv, hi_ptr;
    logic [CI_W-1:0] com_idx;
    logic [7:0]      cur, nv, mask;
    logic [PTR_W-1:0] rd_nxt, wr_nxt;

    assign is_com  = addr >= ADDR_W'(COM_BASE);
    assign is_rsv  = addr == ADDR_W'(RSV_ADDR);
    assign com_idx = CI_W'(addr - ADDR_W'(COM_BASE));
    assign bank    = com_q[IDX_SEL][BANK_W-1:0];
    assign autoinc = com_q[IDX_MODE][AUTOINC_BIT];
    assign hi_ptr  = (bank == '0) && (addr == A_RD_HI || addr == A_WR_HI);
    assign mask    = hi_ptr ? 8'((1 << PTR_HI_W) - 1) : 8'hFF;

    always_comb begin
        if (is_rsv)      cur = '0;
        else if (is_com) cur = com_q[com_idx];
        else             cur = bnk_q[bank][addr];
    end
    assign rdata = cur;

    always_comb begin
        unique case (op)
            OP_WR:   nv = wdata;
            OP_SET:  nv = cur | wdata;
            OP_CLR:  nv = cur & ~wdata;
            default: nv = cur;
        endcase
    end

    assign rd_ptr = {bnk_q[0][A_RD_HI][PTR_HI_W-1:0], bnk_q[0][A_RD_LO]};
    assign wr_ptr = {bnk_q[0][A_WR_HI][PTR_HI_W-1:0], bnk_q[0][A_WR_LO]};
    assign rd_nxt = rd_ptr + PTR_W'(1);
    assign wr_nxt = wr_ptr + PTR_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANK; b++)
                for (int a = 0; a < COM_BASE; a++) bnk_q[b][a] <= '0;
            for (int c = 0; c < NCOM; c++) com_q[c] <= '0;
        end else if (soft_rst) begin
            for (int b = 0; b < NBANK; b++)
                for (int a = 0; a < COM_BASE; a++) bnk_q[b][a] <= '0;
            for (int c = 0; c < NCOM; c++) com_q[c] <= '0;
        end else if (op != OP_NONE) begin
            if (is_com)       com_q[com_idx]    <= nv;
            else if (!is_rsv) bnk_q[bank][addr] <= nv & mask;
        end else if (rd_inc) begin
            bnk_q[0][A_RD_LO] <= rd_nxt[7:0];
            bnk_q[0][A_RD_HI] <= 8'(rd_nxt[PTR_W-1:8]);
        end else if (wr_inc) begin
            bnk_q[0][A_WR_LO] <= wr_nxt[7:0];
            bnk_q[0][A_WR_HI] <= 8'(wr_nxt[PTR_W-1:8]);
        end
    end

    assert_soft_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (bank == '0 && rd_ptr == '0 && wr_ptr == '0 && !autoinc));

    assert_rdptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_inc && op == OP_NONE && !soft_rst) |=> rd_ptr == PTR_W'($past(rd_ptr) + 1'b1));
endmodule

// File: rtl/spi_bank_cmd.sv
module spi_bank_cmd
    import spi_bank_cmd_pkg::*;
#(
    parameter int BUF_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [BANK_W-1:0] bank_o
);
    localparam int BUF_DEPTH = 1 << BUF_AW;

    fsm_e              state, state_d;
    logic              cs_act, byte_done;
    logic [7:0]        rx_byte, tx_byte, reg_rdata;
    logic [ADDR_W-1:0] addr_q, reg_addr;
    reg_op_e           reg_op;
    logic              soft_rst, rd_inc, wr_inc, mem_we, autoinc;
    logic [PTR_W-1:0]  rd_ptr, wr_ptr, rd_sel;
    logic [7:0]        buf_mem [BUF_DEPTH];

    spi_bank_cmd_link u_link (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .tx_byte(tx_byte), .cs_act(cs_act), .byte_done(byte_done),
        .rx_byte(rx_byte), .miso(spi_miso)
    );

    spi_bank_cmd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .op(reg_op), .addr(reg_addr),
        .wdata(rx_byte), .rdata(reg_rdata), .rd_inc(rd_inc), .wr_inc(wr_inc),
        .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .bank(bank_o), .autoinc(autoinc)
    );

    // next state
    always_comb begin
        state_d = state;
        if (!cs_act) begin
            state_d = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: state_d = S_CMD;
                S_CMD: if (byte_done) begin
                    if (rx_byte == CMD_BUFRD)      state_d = S_BUFRD;
                    else if (rx_byte == CMD_BUFWR) state_d = S_BUFWR;
                    else begin
                        unique case (rx_byte[7:5])
                            OPC_RDREG: state_d = S_RDREG;
                            OPC_WRREG: state_d = S_WRREG;
                            OPC_SETB:  state_d = S_SETB;
                            OPC_CLRB:  state_d = S_CLRB;
                            default:   state_d = S_DONE;
                        endcase
                    end
                end
                S_RDREG, S_WRREG, S_SETB, S_CLRB: if (byte_done) state_d = S_DONE;
                S_BUFRD, S_BUFWR, S_DONE: state_d = state;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    // actions
    always_comb begin
        reg_op   = OP_NONE;
        soft_rst = 1'b0;
        rd_inc   = 1'b0;
        wr_inc   = 1'b0;
        mem_we   = 1'b0;
        reg_addr = (state == S_CMD) ? rx_byte[ADDR_W-1:0] : addr_q;
        if (byte_done) begin
            unique case (state)
                S_CMD:   soft_rst = (rx_byte == CMD_RESET);
                S_WRREG: reg_op = OP_WR;
                S_SETB:  reg_op = OP_SET;
                S_CLRB:  reg_op = OP_CLR;
                S_BUFRD: rd_inc = autoinc;
                S_BUFWR: begin mem_we = 1'b1; wr_inc = autoinc; end
                default: ;
            endcase
        end
    end

    assign rd_sel = rd_inc ? rd_ptr + PTR_W'(1) : rd_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            tx_byte <= '0;
        end else if (!cs_act) begin
            tx_byte <= '0;
        end else if (byte_done) begin
            unique case (state)
                S_CMD: begin
                    addr_q <= rx_byte[ADDR_W-1:0];
                    if (rx_byte[7:5] == OPC_RDREG) tx_byte <= reg_rdata;
                    else if (rx_byte == CMD_BUFRD) tx_byte <= buf_mem[BUF_AW'(rd_ptr)];
                    else                           tx_byte <= '0;
                end
                S_BUFRD: tx_byte <= buf_mem[BUF_AW'(rd_sel)];
                default: tx_byte <= '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) buf_mem[BUF_AW'(wr_ptr)] <= rx_byte;
    end

    assert_cs_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> state == S_IDLE);

    assert_cmd_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_CMD |-> spi_miso == 1'b0);

    assert_wrptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUFWR && !autoinc) |=> $stable(wr_ptr));

    assert_one_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_op != OP_NONE, soft_rst, rd_inc, wr_inc}));
endmodule

// File: tb/spi_bank_cmd_bench.sv
`timescale 1ns/1ps
module spi_bank_cmd_bench;
    localparam int HALF  = 8;
    localparam int DEPTH = 2048;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [1:0] bank_o;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    logic [7:0] mreg [4][32];
    logic [7:0] bmem [DEPTH];
    bit         bval [DEPTH];

    always #2 clk = ~clk;

    spi_bank_cmd u_spi_bank_cmd (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .bank_o(bank_o)
    );

    task automatic chk(input string tag, input int got, input int exp, input string what);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    function automatic int mbank(input logic [4:0] a);
        return (a >= 5'd27) ? 0 : int'(mreg[0][31][1:0]);
    endfunction
    function automatic logic [7:0] mget(input logic [4:0] a);
        if (a == 5'd26) return 8'h00;
        return mreg[mbank(a)][a];
    endfunction
    task automatic mput(input logic [4:0] a, input logic [7:0] v);
        int b;
        b = mbank(a);
        if (a == 5'd26) return;
        if (b == 0 && (a == 5'd1 || a == 5'd3)) v = v & 8'h1F;
        mreg[b][a] = v;
    endtask
    function automatic logic [12:0] mptr(input int lo);
        return {mreg[0][lo+1][4:0], mreg[0][lo]};
    endfunction
    task automatic mset_ptr(input int lo, input logic [12:0] p);
        mreg[0][lo]   = p[7:0];
        mreg[0][lo+1] = {3'b000, p[12:8]};
    endtask
    function automatic bit mauto();
        return mreg[0][30][7];
    endfunction
    task automatic mclear();
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < 32; a++) mreg[b][a] = 8'h00;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic frame_begin();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask
    task automatic frame_end();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(10);
    endtask
    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask
    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        spi_bits(tx, 8, rx);
    endtask

    task automatic reg_cmd(input logic [2:0] opc, input logic [4:0] a, input logic [7:0] d);
        logic [7:0] r;
        frame_begin();
        xfer({opc, a}, r);
        xfer(d, r);
        frame_end();
        case (opc)
            3'b010:  mput(a, d);
            3'b100:  mput(a, mget(a) | d);
            3'b101:  mput(a, mget(a) & ~d);
            default: ;
        endcase
    endtask

    task automatic reg_check(input logic [4:0] a, input string tag);
        logic [7:0] c, r;
        frame_begin();
        xfer({3'b000, a}, c);
        xfer(8'h00, r);
        frame_end();
        chk("R11", c, 0, "miso during command byte");
        chk(tag, r, mget(a), $sformatf("read addr %0h bank %0d", a, mbank(a)));
    endtask

    task automatic buf_wr(input int n);
        logic [7:0] r, d;
        logic [12:0] p;
        frame_begin();
        xfer(8'h7A, r);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            xfer(d, r);
            p = mptr(2);
            bmem[p % DEPTH] = d;
            bval[p % DEPTH] = 1'b1;
            if (mauto()) mset_ptr(2, p + 13'd1);
        end
        frame_end();
    endtask

    task automatic buf_rd(input int n, input string tag);
        logic [7:0] r;
        logic [12:0] p;
        frame_begin();
        xfer(8'h3A, r);
        chk("R11", r, 0, "miso during buffer command");
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, r);
            p = mptr(0);
            if (bval[p % DEPTH]) chk(tag, r, bmem[p % DEPTH], $sformatf("buffer ptr %0h", p));
            if (mauto()) mset_ptr(0, p + 13'd1);
        end
        frame_end();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        void'($urandom(32'd4242));
        mclear();
        for (int i = 0; i < DEPTH; i++) bval[i] = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // reset state
        chk("R12", bank_o, 0, "bank after reset");
        reg_check(5'h1F, "R4");

        // write, set, clear
        reg_cmd(3'b010, 5'h05, 8'hA5);
        reg_check(5'h05, "R2");
        reg_cmd(3'b100, 5'h05, 8'h0F);
        reg_check(5'h05, "R3");
        reg_cmd(3'b101, 5'h05, 8'hF0);
        reg_check(5'h05, "R3");

        // read followed by extra bytes
        frame_begin();
        xfer(8'h05, r);
        xfer(8'h00, r);
        chk("R1", r, 8'h0F, "read data byte");
        xfer(8'h00, r);
        chk("R1", r, 0, "byte after read data");
        frame_end();

        // banks
        reg_cmd(3'b010, 5'h1F, 8'h01);
        chk("R12", bank_o, 1, "bank after select");
        reg_cmd(3'b010, 5'h05, 8'h3C);
        reg_check(5'h05, "R4");
        reg_cmd(3'b010, 5'h1B, 8'h77);
        reg_cmd(3'b010, 5'h1F, 8'h02);
        reg_check(5'h1B, "R5");
        reg_cmd(3'b010, 5'h1F, 8'h00);
        reg_check(5'h05, "R4");

        // reserved and pointer-high mask
        reg_cmd(3'b010, 5'h1A, 8'hFF);
        reg_check(5'h1A, "R6");
        reg_cmd(3'b010, 5'h01, 8'hFF);
        reg_check(5'h01, "R6");

        // buffer streaming with auto-increment
        reg_cmd(3'b010, 5'h1E, 8'h80);
        reg_cmd(3'b010, 5'h02, 8'h10);
        reg_cmd(3'b010, 5'h03, 8'h00);
        buf_wr(3);
        reg_check(5'h02, "R8");
        reg_cmd(3'b010, 5'h00, 8'h10);
        reg_cmd(3'b010, 5'h01, 8'h00);
        buf_rd(3, "R7");
        reg_check(5'h00, "R8");

        // auto-increment off: same location
        reg_cmd(3'b010, 5'h1E, 8'h00);
        reg_cmd(3'b010, 5'h02, 8'h20);
        buf_wr(2);
        reg_check(5'h02, "R8");
        reg_cmd(3'b010, 5'h00, 8'h20);
        buf_rd(2, "R8");

        // wrap at top of pointer range
        reg_cmd(3'b010, 5'h1E, 8'h80);
        reg_cmd(3'b010, 5'h02, 8'hFF);
        reg_cmd(3'b010, 5'h03, 8'h1F);
        buf_wr(2);
        reg_check(5'h02, "R8");
        reg_check(5'h03, "R8");
        reg_cmd(3'b010, 5'h00, 8'hFF);
        reg_cmd(3'b010, 5'h01, 8'h1F);
        buf_rd(2, "R8");
        reg_check(5'h00, "R8");

        // frame cut in the middle of the data byte
        frame_begin();
        xfer({3'b010, 5'h05}, r);
        spi_bits(8'hFF, 4, r);
        frame_end();
        reg_check(5'h05, "R10");
        // undefined opcode with a data byte
        frame_begin();
        xfer(8'hC5, r);
        xfer(8'h99, r);
        frame_end();
        reg_check(5'h05, "R10");

        // random traffic
        for (int it = 0; it < 110; it++) begin
            int sel;
            logic [4:0] a;
            logic [7:0] d;
            sel = int'($urandom % 10);
            a   = 5'($urandom);
            d   = 8'($urandom);
            case (sel)
                0, 1, 2: reg_cmd(3'b010, a, d);
                3:       reg_cmd(3'b100, a, d);
                4:       reg_cmd(3'b101, a, d);
                5, 6:    reg_check(a, "R2");
                7:       buf_wr(1 + int'($urandom % 4));
                8:       buf_rd(1 + int'($urandom % 4), "R7");
                default: reg_cmd(3'b010, 5'h1F, d);
            endcase
            wait_clk(2);
            chk("R12", bank_o, int'(mreg[0][31][1:0]), "bank output");
        end

        // soft reset
        reg_cmd(3'b010, 5'h1F, 8'h03);
        reg_cmd(3'b010, 5'h1E, 8'h80);
        frame_begin();
        xfer(8'hFF, r);
        frame_end();
        mclear();
        wait_clk(2);
        chk("R9", bank_o, 0, "bank after soft reset");
        reg_check(5'h1E, "R9");
        reg_check(5'h1F, "R9");
        reg_check(5'h00, "R9");
        reg_check(5'h03, "R9");
        reg_check(5'h05, "R9");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule